// File: doc/BRIEF.md
# Pipeline Redirect and Hazard Control

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) moves forward. It reads the opcode in decode and execute, the decode instruction's two source specifiers and their read enables, the destination specifiers and write enables of execute, memory and writeback, and the zero flag from execute. From these it drives three mux selects: where the next PC comes from, what the decode instruction register loads, and whether execute takes the decode instruction or a bubble.

Three situations are handled. An unconditional jump seen in decode redirects fetch and squashes the one instruction fetched behind it. A conditional branch that resolves taken in execute redirects fetch, squashes both younger instructions and cancels any interlock, because the decode instruction is on the wrong path. A read-after-write dependence of the decode instruction on an older, still-writing instruction holds decode and feeds a bubble into execute until the producer has left writeback. All outputs are combinational in the current stage contents. The PC and stage registers live in the datapath: they update on the rising clock edge, and a synchronous reset loads nop into every stage.

Top module: `redirect_hazard_ctl`

## Requirements
- R1: Opcode codes are OTHER=0, J=1, JAL=2, JR=3, JALR=4, BEQZ=5, BNEZ=6. With no jump in decode, no taken branch in execute and no hazard, pc_sel is 0 (PC+4), ir_d_sel is 0 (instruction memory) and ir_e_sel is 0 (forward).
- R2: A branch is taken when execute holds BEQZ with zero_e=1 or BNEZ with zero_e=0; then pc_sel is 3 (branch target) whatever decode holds.
- R3: Without a taken branch, J or JAL in decode gives pc_sel 1 (absolute target) and JR or JALR in decode gives pc_sel 2 (register target).
- R4: A jump in decode sets ir_d_sel to 2 (nop) and by itself leaves ir_e_sel at 0, so the jump moves on without a stall.
- R5: A taken branch sets ir_d_sel to 2 (nop) and ir_e_sel to 1 (nop).
- R6: The decode instruction is stalled when rs_d with rs_rd_en_d, or rt_d with rt_rd_en_d, equals the destination of the execute, memory or writeback instruction whose write enable is set; a stall gives ir_d_sel 1 (hold, PC register held by the datapath) and ir_e_sel 1 (nop).
- R7: A taken branch cancels a stall: ir_d_sel is never 1 while pc_sel is 3.
- R8: A source specifier of zero never causes a stall.
- R9: A branch that is not taken has no effect on any select.
- R10: Decode select priority is taken branch (nop), then jump in decode (nop), then stall (hold), then instruction memory.
- R11: In a running pipeline, the target of a jump enters execute two cycles after the jump, the target of a taken branch three cycles after the branch, and an instruction reading a register written by its immediate predecessor enters execute four cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_d | input | OP_W | Opcode of the decode instruction |
| op_e | input | OP_W | Opcode of the execute instruction |
| zero_e | input | 1 | Zero flag of the execute-stage operand |
| rs_d | input | REG_W | First source specifier in decode |
| rs_rd_en_d | input | 1 | First source is read |
| rt_d | input | REG_W | Second source specifier in decode |
| rt_rd_en_d | input | 1 | Second source is read |
| dst_e | input | REG_W | Destination specifier in execute |
| wr_en_e | input | 1 | Execute instruction writes a register |
| dst_m | input | REG_W | Destination specifier in memory |
| wr_en_m | input | 1 | Memory instruction writes a register |
| dst_w | input | REG_W | Destination specifier in writeback |
| wr_en_w | input | 1 | Writeback instruction writes a register |
| pc_sel | output | 2 | 0 PC+4, 1 absolute jump, 2 register jump, 3 branch target |
| ir_d_sel | output | 2 | 0 instruction memory, 1 hold, 2 nop |
| ir_e_sel | output | 1 | 0 forward decode instruction, 1 nop |

## Verification
A vector table sweeps each jump opcode, both branch kinds with both zero values, and hazards on each source against each older stage, so that taken and not-taken branches, absolute and register jumps, and real matches and near-misses (read enable off, write enable off, register zero, differing specifiers) are told apart. Combined cases, a branch over a stall and a jump over a stall, separate the priority order from plain single-cause behaviour. A small pipeline model in the bench then runs short programs to measure bubble counts after a jump, after taken and not-taken branches, and behind a dependent instruction.

// File: rtl/redirect_hazard_ctl.sv
module redirect_hazard_ctl #(
  parameter int OP_W  = 3,
  parameter int REG_W = 5,
  parameter logic [OP_W-1:0] OP_J    = 1,
  parameter logic [OP_W-1:0] OP_JAL  = 2,
  parameter logic [OP_W-1:0] OP_JR   = 3,
  parameter logic [OP_W-1:0] OP_JALR = 4,
  parameter logic [OP_W-1:0] OP_BEQZ = 5,
  parameter logic [OP_W-1:0] OP_BNEZ = 6
) (
  input  logic [OP_W-1:0]  op_d,
  input  logic [OP_W-1:0]  op_e,
  input  logic             zero_e,
  input  logic [REG_W-1:0] rs_d,
  input  logic             rs_rd_en_d,
  input  logic [REG_W-1:0] rt_d,
  input  logic             rt_rd_en_d,
  input  logic [REG_W-1:0] dst_e,
  input  logic             wr_en_e,
  input  logic [REG_W-1:0] dst_m,
  input  logic             wr_en_m,
  input  logic [REG_W-1:0] dst_w,
  input  logic             wr_en_w,
  output logic [1:0]       pc_sel,
  output logic [1:0]       ir_d_sel,
  output logic             ir_e_sel
);
  localparam logic [1:0] PC_SEQ = 2'd0, PC_ABS = 2'd1, PC_REG = 2'd2, PC_BR = 2'd3;
  localparam logic [1:0] IRD_MEM = 2'd0, IRD_HOLD = 2'd1, IRD_NOP = 2'd2;
  localparam int NSTG = 3;

  logic [REG_W-1:0] dst   [NSTG];
  logic             wr_en [NSTG];
  logic [NSTG-1:0]  rs_hit, rt_hit;

  assign dst[0] = dst_e;  assign wr_en[0] = wr_en_e;
  assign dst[1] = dst_m;  assign wr_en[1] = wr_en_m;
  assign dst[2] = dst_w;  assign wr_en[2] = wr_en_w;

  for (genvar s = 0; s < NSTG; s++) begin : g_cmp
    assign rs_hit[s] = rs_rd_en_d && wr_en[s] && (rs_d != '0) && (rs_d == dst[s]);
    assign rt_hit[s] = rt_rd_en_d && wr_en[s] && (rt_d != '0) && (rt_d == dst[s]);
  end

  logic hazard, br_taken, stall, jmp_abs, jmp_reg;

  assign hazard   = |{rs_hit, rt_hit};
  assign br_taken = ((op_e == OP_BEQZ) && zero_e) || ((op_e == OP_BNEZ) && !zero_e);
  assign stall    = hazard && !br_taken;
  assign jmp_abs  = (op_d == OP_J)  || (op_d == OP_JAL);
  assign jmp_reg  = (op_d == OP_JR) || (op_d == OP_JALR);

  assign pc_sel   = br_taken ? PC_BR : jmp_abs ? PC_ABS : jmp_reg ? PC_REG : PC_SEQ;
  assign ir_d_sel = (br_taken || jmp_abs || jmp_reg) ? IRD_NOP : stall ? IRD_HOLD : IRD_MEM;
  assign ir_e_sel = br_taken || stall;

  always_comb begin
    assert_branch_kills_both_R5: assert (pc_sel != PC_BR || (ir_d_sel == IRD_NOP && ir_e_sel))
      else $error("taken branch did not squash both younger instructions");
    assert_no_hold_on_branch_R7: assert (!(pc_sel == PC_BR && ir_d_sel == IRD_HOLD))
      else $error("decode held under a taken branch");
    assert_hold_needs_match_R6: assert (ir_d_sel != IRD_HOLD || hazard)
      else $error("hold without a register match");
    assert_hold_bubbles_exec_R6: assert (ir_d_sel != IRD_HOLD || ir_e_sel)
      else $error("hold without a bubble into execute");
    assert_jump_kills_fetch_R4: assert (!(pc_sel == PC_ABS || pc_sel == PC_REG) || ir_d_sel == IRD_NOP)
      else $error("jump redirect without squashing the fetched instruction");
  end
endmodule

// File: tb/redirect_hazard_ctl_tb_top.sv
module redirect_hazard_ctl_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0] op_d, op_e;
  logic zero_e, rs_rd_en_d, rt_rd_en_d, wr_en_e, wr_en_m, wr_en_w;
  logic [4:0] rs_d, rt_d, dst_e, dst_m, dst_w;
  logic [1:0] pc_sel, ir_d_sel;
  logic ir_e_sel;

  redirect_hazard_ctl dut_i (
    .op_d(op_d), .op_e(op_e), .zero_e(zero_e),
    .rs_d(rs_d), .rs_rd_en_d(rs_rd_en_d), .rt_d(rt_d), .rt_rd_en_d(rt_rd_en_d),
    .dst_e(dst_e), .wr_en_e(wr_en_e), .dst_m(dst_m), .wr_en_m(wr_en_m),
    .dst_w(dst_w), .wr_en_w(wr_en_w),
    .pc_sel(pc_sel), .ir_d_sel(ir_d_sel), .ir_e_sel(ir_e_sel));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] opd, ope; logic z;
    logic [4:0] rs, rt; logic rse, rte;
    logic [4:0] de; logic we; logic [4:0] dm; logic wm; logic [4:0] dw; logic ww;
    logic [1:0] epc, eird; logic eire; logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd0,3'd0,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd0,2'd0,1'b0, 4'd1},  // R1 idle
    '{3'd1,3'd0,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd1,2'd2,1'b0, 4'd3},  // R3 J
    '{3'd2,3'd0,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd1,2'd2,1'b0, 4'd3},  // R3 JAL
    '{3'd3,3'd0,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd2,2'd2,1'b0, 4'd3},  // R3 JR
    '{3'd4,3'd0,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd2,2'd2,1'b0, 4'd4},  // R4 JALR no stall
    '{3'd0,3'd5,1'b1, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd3,2'd2,1'b1, 4'd2},  // R2 BEQZ taken
    '{3'd0,3'd6,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd3,2'd2,1'b1, 4'd5},  // R5 BNEZ taken
    '{3'd0,3'd5,1'b0, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd0,2'd0,1'b0, 4'd9},  // R9 BEQZ not taken
    '{3'd1,3'd6,1'b1, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd1,2'd2,1'b0, 4'd9},  // R9 BNEZ not taken, J
    '{3'd3,3'd5,1'b1, 5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd3,2'd2,1'b1, 4'd10}, // R10 branch over JR
    '{3'd0,3'd0,1'b0, 5'd7,5'd0,1'b1,1'b0, 5'd7,1'b1,5'd0,1'b0,5'd0,1'b0, 2'd0,2'd1,1'b1, 4'd6},  // R6 rs vs E
    '{3'd0,3'd0,1'b0, 5'd0,5'd9,1'b0,1'b1, 5'd0,1'b0,5'd9,1'b1,5'd0,1'b0, 2'd0,2'd1,1'b1, 4'd6},  // R6 rt vs M
    '{3'd0,3'd0,1'b0, 5'd12,5'd0,1'b1,1'b0, 5'd0,1'b0,5'd0,1'b0,5'd12,1'b1, 2'd0,2'd1,1'b1, 4'd6}, // R6 rs vs W
    '{3'd0,3'd0,1'b0, 5'd7,5'd0,1'b0,1'b0, 5'd7,1'b1,5'd0,1'b0,5'd0,1'b0, 2'd0,2'd0,1'b0, 4'd6},  // R6 read enable off
    '{3'd0,3'd0,1'b0, 5'd7,5'd0,1'b1,1'b0, 5'd7,1'b0,5'd0,1'b0,5'd0,1'b0, 2'd0,2'd0,1'b0, 4'd6},  // R6 write enable off
    '{3'd0,3'd0,1'b0, 5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,5'd0,1'b1,5'd0,1'b1, 2'd0,2'd0,1'b0, 4'd8},  // R8 register zero
    '{3'd0,3'd5,1'b1, 5'd7,5'd0,1'b1,1'b0, 5'd7,1'b1,5'd0,1'b0,5'd0,1'b0, 2'd3,2'd2,1'b1, 4'd7},  // R7 branch cancels stall
    '{3'd1,3'd0,1'b0, 5'd0,5'd4,1'b0,1'b1, 5'd0,1'b0,5'd0,1'b0,5'd4,1'b1, 2'd1,2'd2,1'b1, 4'd10}, // R10 jump over hold
    '{3'd0,3'd0,1'b0, 5'd3,5'd0,1'b1,1'b0, 5'd0,1'b0,5'd4,1'b1,5'd0,1'b0, 2'd0,2'd0,1'b0, 4'd6}   // R6 specifier mismatch
  };

  typedef struct packed {
    logic [7:0] id; logic [2:0] op; logic [4:0] rs, rt; logic rse, rte;
    logic [4:0] wd; logic we; logic zf; logic [4:0] tgt;
  } ins_t;

  ins_t prog [32];
  int   ecyc [16];
  ins_t sd, se, sm, sw;

  function automatic ins_t mk(int id, int op, int rs, int rse, int wd, int we, int zf, int tgt);
    ins_t i = '0;
    i.id = 8'(id); i.op = 3'(op); i.rs = 5'(rs); i.rse = 1'(rse);
    i.wd = 5'(wd); i.we = 1'(we); i.zf = 1'(zf); i.tgt = 5'(tgt);
    return i;
  endfunction

  task automatic clear_prog();
    for (int k = 0; k < 32; k++) prog[k] = '0;
    for (int k = 0; k < 16; k++) ecyc[k] = 0;
  endtask

  task automatic run_pipe(input int ncyc);
    logic [4:0] pc;
    rst = 1'b1;
    @(posedge clk);
    sd = '0; se = '0; sm = '0; sw = '0; pc = '0;
    rst = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      op_d = sd.op; rs_d = sd.rs; rs_rd_en_d = sd.rse; rt_d = sd.rt; rt_rd_en_d = sd.rte;
      op_e = se.op; zero_e = se.zf;
      dst_e = se.wd; wr_en_e = se.we; dst_m = sm.wd; wr_en_m = sm.we; dst_w = sw.wd; wr_en_w = sw.we;
      #5;
      sw = sm; sm = se;
      se = ir_e_sel ? ins_t'('0) : sd;
      case (pc_sel)
        2'd3: begin sd = '0; pc = sm.tgt; end
        2'd1, 2'd2: begin pc = sd.tgt; sd = '0; end
        default: if (ir_d_sel == 2'd0) begin sd = prog[pc]; pc = pc + 5'd1; end
      endcase
      if (se.id != 0) ecyc[se.id] = c;
    end
  endtask

  task automatic drive_vec(input vec_t v);
    @(negedge clk);
    op_d = v.opd; op_e = v.ope; zero_e = v.z;
    rs_d = v.rs; rt_d = v.rt; rs_rd_en_d = v.rse; rt_rd_en_d = v.rte;
    dst_e = v.de; wr_en_e = v.we; dst_m = v.dm; wr_en_m = v.wm; dst_w = v.dw; wr_en_w = v.ww;
    #5;
  endtask

  initial begin
    vec_t z0 = '0;
    drive_vec(z0);
    repeat (2) @(posedge clk);
    // R1 reset state: all stages nop
    chk(pc_sel == 2'd0 && ir_d_sel == 2'd0 && ir_e_sel == 1'b0, "R1 reset", {pc_sel, ir_d_sel, ir_e_sel}, 0);

    for (int k = 0; k < NV; k++) begin
      drive_vec(VECS[k]);
      chk(pc_sel == VECS[k].epc, $sformatf("R%0d vec%0d pc_sel", VECS[k].req, k), pc_sel, VECS[k].epc);
      chk(ir_d_sel == VECS[k].eird, $sformatf("R%0d vec%0d ir_d_sel", VECS[k].req, k), ir_d_sel, VECS[k].eird);
      chk(ir_e_sel == VECS[k].eire, $sformatf("R%0d vec%0d ir_e_sel", VECS[k].req, k), ir_e_sel, VECS[k].eire);
    end

    // R11 jump: one bubble, fall-through never executes
    clear_prog();
    prog[0] = mk(1, 0, 0, 0, 0, 0, 0, 0);
    prog[1] = mk(2, 1, 0, 0, 0, 0, 0, 10);
    prog[2] = mk(3, 0, 0, 0, 0, 0, 0, 0);
    prog[10] = mk(4, 0, 0, 0, 0, 0, 0, 0);
    run_pipe(12);
    chk(ecyc[4] - ecyc[2] == 2 && ecyc[2] != 0, "R11 jump gap", ecyc[4] - ecyc[2], 2);
    chk(ecyc[3] == 0, "R4 jump squash", ecyc[3], 0);

    // R11 taken branch: two bubbles
    clear_prog();
    prog[0] = mk(1, 0, 0, 0, 0, 0, 0, 0);
    prog[1] = mk(2, 5, 0, 0, 0, 0, 1, 20);
    prog[2] = mk(3, 0, 0, 0, 0, 0, 0, 0);
    prog[3] = mk(4, 0, 0, 0, 0, 0, 0, 0);
    prog[20] = mk(5, 0, 0, 0, 0, 0, 0, 0);
    run_pipe(12);
    chk(ecyc[5] - ecyc[2] == 3 && ecyc[2] != 0, "R11 branch gap", ecyc[5] - ecyc[2], 3);
    chk(ecyc[3] == 0 && ecyc[4] == 0, "R5 branch squash", ecyc[3] + ecyc[4], 0);

    // R9 not-taken branch: no bubble
    clear_prog();
    prog[0] = mk(1, 6, 0, 0, 0, 0, 1, 20);
    prog[1] = mk(2, 0, 0, 0, 0, 0, 0, 0);
    run_pipe(8);
    chk(ecyc[2] - ecyc[1] == 1 && ecyc[1] != 0, "R9 not-taken gap", ecyc[2] - ecyc[1], 1);

    // R11 dependent instruction waits for producer to leave writeback
    clear_prog();
    prog[0] = mk(1, 0, 0, 0, 5, 1, 0, 0);
    prog[1] = mk(2, 0, 5, 1, 6, 1, 0, 0);
    prog[2] = mk(3, 0, 0, 0, 0, 0, 0, 0);
    run_pipe(12);
    chk(ecyc[2] - ecyc[1] == 4 && ecyc[1] != 0, "R11 stall gap", ecyc[2] - ecyc[1], 4);
    chk(ecyc[3] - ecyc[2] == 1, "R6 resume after stall", ecyc[3] - ecyc[2], 1);

    // R8 reading register zero after a write to zero: no stall
    clear_prog();
    prog[0] = mk(1, 0, 0, 0, 0, 1, 0, 0);
    prog[1] = mk(2, 0, 0, 1, 0, 0, 0, 0);
    run_pipe(8);
    chk(ecyc[2] - ecyc[1] == 1 && ecyc[1] != 0, "R8 zero no stall", ecyc[2] - ecyc[1], 1);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule